// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked request port and an external asynchronous static RAM. The RAM is 32 bits wide and built from four independent byte lanes. The lanes share 19 address lines and one active-low output enable. Each lane has its own active-low chip enable and write enable. A request carries a read/write flag, an address, a 32-bit word and a 4-bit lane mask. Only the lanes named in the mask are strobed, so 8-, 16-, 24- and 32-bit accesses use the same sequence.

Every analog limit of the RAM is a time in picoseconds, given as a parameter. The controller turns each limit into a whole number of clock cycles, rounded up and never less than one. It then holds each phase of the access for that many cycles. The limits covered are write pulse width, address setup and hold, data setup and hold, the quiet time after write enable falls, write recovery, the minimum cycle time and read access time. Read data comes back with a one-cycle valid strobe. A ready flag is high only while the controller is free to accept a request.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, every `sram_ce_n` and `sram_we_n` bit is 1, `sram_oe_n` is 1, `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. From that edge `req_ready` stays 0 for the whole access, which lasts ASU+PW+HLD+RECW cycles for a write and ACC+RECR cycles for a read. A request offered while busy is dropped and never reaches the RAM.
- R3: Bit i of `req_lanes` selects data bits [8i+7:8i] and lane i's chip enable and write enable. Lanes whose bit is 0 keep both enables at 1 for the whole access.
- R4: A write starts with ASU = ceil(T_ASU/T_CLK) cycles in which the selected chip enables are 0, the address is valid and every write enable is 1.
- R5: Each selected lane's write enable is then 0 for PW = max(ceil(T_WP), ceil(T_WZ)+ceil(T_DSU)) cycles, and a write enable is never 0 while its chip enable is 1.
- R6: During the write pulse, the data drivers (`sram_dq_oe`) stay off for the first ceil(T_WZ) cycles and are on for the rest of it. Output enable stays 1 for the whole write, and data is never driven while output enable is 0.
- R7: After write enable rises, the address, chip enables and driven data are held for HLD = max(ceil(T_AH), ceil(T_DH)) cycles. The address stays stable while any chip enable is 0.
- R8: Every access ends with a recovery phase in which all enables are 1 and no data is driven. For a write this phase lasts RECW = max(ceil(T_WREC), ceil(T_CYC) - ASU - PW - HLD, 1) cycles, and for a read RECR = max(ceil(T_CYC) - ACC, 1) cycles.
- R9: A read holds the selected chip enables and output enable at 0, with all write enables at 1, for ACC = ceil(T_ACC) cycles. The bus is sampled at the edge that ends those cycles. `rsp_valid` is 1 for exactly the next cycle, and `rsp_rdata` then holds the sampled bytes, with unselected lanes reading 0.
- R10: A request with `req_lanes` = 0 asserts no RAM strobe and keeps `req_ready` at 1. If it is a read, `rsp_valid` is 1 on the cycle after acceptance with `rsp_rdata` = 0. If it is a write, memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write word, lane i in bits [8i+7:8i] |
| req_lanes | input | 4 | Lane mask |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read word, unselected lanes 0 |
| sram_addr | output | 19 | RAM address lines |
| sram_ce_n | output | 4 | Per-lane chip enable, active low |
| sram_we_n | output | 4 | Per-lane write enable, active low |
| sram_oe_n | output | 1 | Shared output enable, active low |
| sram_dq_o | output | 32 | Data driven toward the RAM |
| sram_dq_oe | output | 4 | Per-lane data driver enable for the tri-state pad |
| sram_dq_i | input | 32 | Data returned from the RAM bus |

## Verification
All RAM-side outputs are registered, so the first phase of an access appears on the first cycle after the accepting edge. The bench counts from that edge and predicts each cycle's strobe, driver and ready values from the phase lengths it derives. It samples on the falling edge of every cycle up to the first idle one. Read data is due on cycle ACC+1, and a zero-mask read responds on cycle 1. Both are checked on exactly those cycles. A byte-lane model of the RAM latches data on each rising write enable, so read-back compares what the pins delivered against a reference image built from the requests.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD,
        PH_RECOVER
    } phase_e;

    // ceiling division of a time limit by the clock period, at least one cycle
    function automatic int to_cycles(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_d,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (load)                cnt_d = load_val;
        else if (cnt_q == '0)    cnt_d = '0;
        else                     cnt_d = cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sram_lane_drive.sv
module sram_lane_drive #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_d,
    input  logic              ce_d,
    input  logic              we_d,
    input  logic              drv_d,
    input  logic [LANE_W-1:0] wdata_d,
    output logic              ce_n_q,
    output logic              we_n_q,
    output logic              dq_oe_q,
    output logic [LANE_W-1:0] dq_o_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            dq_o_q  <= '0;
        end else begin
            ce_n_q  <= !(sel_d && ce_d);
            we_n_q  <= !(sel_d && we_d);
            dq_oe_q <= sel_d && drv_d;
            dq_o_q  <= wdata_d;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int LANES      = 4,
    parameter int LANE_W     = 8,
    parameter int T_CLK_PS   = 4000,
    parameter int T_ACC_PS   = 15000,
    parameter int T_CYC_PS   = 15000,
    parameter int T_WP_PS    = 12000,
    parameter int T_DSU_PS   = 7000,
    parameter int T_DH_PS    = 2000,
    parameter int T_ASU_PS   = 1000,
    parameter int T_AH_PS    = 2000,
    parameter int T_WZ_PS    = 5000,
    parameter int T_WREC_PS  = 3000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_lanes,
    output logic                     rsp_valid,
    output logic [LANES*LANE_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]        sram_addr,
    output logic [LANES-1:0]         sram_ce_n,
    output logic [LANES-1:0]         sram_we_n,
    output logic                     sram_oe_n,
    output logic [LANES*LANE_W-1:0]  sram_dq_o,
    output logic [LANES-1:0]         sram_dq_oe,
    input  logic [LANES*LANE_W-1:0]  sram_dq_i
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int ACC_C  = to_cycles(T_ACC_PS, T_CLK_PS);
    localparam int CYC_C  = to_cycles(T_CYC_PS, T_CLK_PS);
    localparam int ASU_C  = to_cycles(T_ASU_PS, T_CLK_PS);
    localparam int WZ_C   = to_cycles(T_WZ_PS, T_CLK_PS);
    localparam int PW_C   = max2(to_cycles(T_WP_PS, T_CLK_PS),
                                 WZ_C + to_cycles(T_DSU_PS, T_CLK_PS));
    localparam int HLD_C  = max2(to_cycles(T_AH_PS, T_CLK_PS),
                                 to_cycles(T_DH_PS, T_CLK_PS));
    localparam int RECW_C = max2(max2(to_cycles(T_WREC_PS, T_CLK_PS),
                                      CYC_C - ASU_C - PW_C - HLD_C), 1);
    localparam int RECR_C = max2(CYC_C - ACC_C, 1);
    localparam int MAX_C  = max2(max2(max2(ACC_C, ASU_C), max2(PW_C, HLD_C)),
                                 max2(RECW_C, RECR_C));
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int DRV_AT = PW_C - 1 - WZ_C;   // countdown value where driving starts

    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    lanes;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
        logic                oe_n;
    } ctrl_s;

    ctrl_s            d, q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt_d;
    logic             tmr_last;
    logic             ce_req_d, we_req_d, drv_req_d;

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        return r;
    endfunction

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_d    (tmr_cnt_d),
        .last     (tmr_last)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_lanes == '0) begin
                        d.rvalid = !req_write;
                        d.rdata  = '0;
                    end else begin
                        d.addr   = req_addr;
                        d.lanes  = req_lanes;
                        d.wdata  = req_wdata;
                        tmr_load = 1'b1;
                        if (req_write) begin
                            d.ph    = PH_WR_SETUP;
                            tmr_val = CNT_W'(ASU_C - 1);
                        end else begin
                            d.ph    = PH_RD_ACC;
                            tmr_val = CNT_W'(ACC_C - 1);
                        end
                    end
                end
            end
            PH_RD_ACC: if (tmr_last) begin
                d.rdata  = sram_dq_i & lane_bits(q.lanes);
                d.rvalid = 1'b1;
                d.ph     = PH_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RECR_C - 1);
            end
            PH_WR_SETUP: if (tmr_last) begin
                d.ph     = PH_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PW_C - 1);
            end
            PH_WR_PULSE: if (tmr_last) begin
                d.ph     = PH_WR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HLD_C - 1);
            end
            PH_WR_HOLD: if (tmr_last) begin
                d.ph     = PH_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RECW_C - 1);
            end
            PH_RECOVER: if (tmr_last) d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase
        d.oe_n    = (d.ph != PH_RD_ACC);
        ce_req_d  = (d.ph == PH_RD_ACC) || (d.ph == PH_WR_SETUP) ||
                    (d.ph == PH_WR_PULSE) || (d.ph == PH_WR_HOLD);
        we_req_d  = (d.ph == PH_WR_PULSE);
        drv_req_d = ((d.ph == PH_WR_PULSE) && (tmr_cnt_d <= CNT_W'(DRV_AT))) ||
                    (d.ph == PH_WR_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_drive #(.LANE_W(LANE_W)) i_drive (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_d   (d.lanes[g]),
            .ce_d    (ce_req_d),
            .we_d    (we_req_d),
            .drv_d   (drv_req_d),
            .wdata_d (d.wdata[g*LANE_W +: LANE_W]),
            .ce_n_q  (sram_ce_n[g]),
            .we_n_q  (sram_we_n[g]),
            .dq_oe_q (sram_dq_oe[g]),
            .dq_o_q  (sram_dq_o[g*LANE_W +: LANE_W])
        );
    end

    assign req_ready = (q.ph == PH_IDLE);
    assign rsp_valid = q.rvalid;
    assign rsp_rdata = q.rdata;
    assign sram_addr = q.addr;
    assign sram_oe_n = q.oe_n;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [LANES-1:0]  sram_ce_n,
    input logic [LANES-1:0]  sram_we_n,
    input logic              sram_oe_n,
    input logic [LANES-1:0]  sram_dq_oe
);
    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sram_dq_oe) |-> sram_oe_n);

    // R5
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~sram_we_n)) |-> ((~sram_we_n & sram_ce_n) == '0));

    // R9
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (&sram_we_n));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sram_ce_n) |-> !req_ready);

    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sram_ce_n) && $past(!(&sram_ce_n))) |-> $stable(sram_addr));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R7
        we_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sram_we_n[g]) |-> (sram_dq_oe[g] && !sram_ce_n[g]));

        // R4
        we_fall_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sram_we_n[g]) |-> $past(!sram_ce_n[g]));
    end
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
    localparam int CLK_PS = 4000;
    function automatic int cyc(input int t_ps);
        int c;
        c = (t_ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int ACC  = cyc(15000);
    localparam int ASU  = cyc(1000);
    localparam int WZ   = cyc(5000);
    localparam int PW   = mx(cyc(12000), WZ + cyc(7000));
    localparam int HLD  = mx(cyc(2000), cyc(2000));
    localparam int RECW = mx(mx(cyc(3000), cyc(15000) - ASU - PW - HLD), 1);
    localparam int RECR = mx(cyc(15000) - ACC, 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_lanes = '0;
    logic        req_ready, rsp_valid, sram_oe_n;
    logic [31:0] rsp_rdata, sram_dq_o;
    logic [31:0] sram_dq_i = '0;
    logic [18:0] sram_addr;
    logic [3:0]  sram_ce_n, sram_we_n, sram_dq_oe;

    int checks = 0, fails = 0, cycles = 0;
    logic [31:0] ref_mem  [logic [18:0]];
    logic [31:0] sram_mem [logic [18:0]];

    always #2 clk = ~clk;   // 250 MHz

    sram_lane_ctrl i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    // byte-lane RAM model: latch on rising write enable
    for (genvar g = 0; g < 4; g++) begin : g_model
        always @(posedge sram_we_n[g]) begin
            if (rst_n && !sram_ce_n[g]) begin
                logic [31:0] w;
                w = sram_mem.exists(sram_addr) ? sram_mem[sram_addr] : 32'h0;
                w[g*8 +: 8] = sram_dq_oe[g] ? sram_dq_o[g*8 +: 8] : 8'hEE;
                sram_mem[sram_addr] = w;
            end
        end
    end

    always @(negedge clk) begin
        logic [31:0] w;
        w = sram_mem.exists(sram_addr) ? sram_mem[sram_addr] : 32'h0;
        for (int l = 0; l < 4; l++)
            sram_dq_i[l*8 +: 8] <= (!sram_oe_n && !sram_ce_n[l] && sram_we_n[l])
                                   ? w[l*8 +: 8] : 8'hA5;
    end

    function automatic logic [31:0] lbits(input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    // expected {ce_n, we_n, oe_n, dq_oe, ready, rsp_valid} on cycle k after acceptance
    function automatic logic [14:0] exp_vec(input logic wr, input logic [3:0] m,
                                            input int k, input int total);
        logic [3:0] ce = 4'hF, we = 4'hF, oe_d = 4'h0;
        logic oe = 1'b1, rdy, rv = 1'b0;
        rdy = (k > total);
        if (m == 4'h0) begin
            rv = !wr && (k == 1);
        end else if (wr) begin
            if (k <= ASU + PW + HLD) ce = ~m;
            if (k > ASU && k <= ASU + PW) begin
                we = ~m;
                if (k - ASU - 1 >= WZ) oe_d = m;
            end
            if (k > ASU + PW && k <= ASU + PW + HLD) oe_d = m;
        end else begin
            if (k <= ACC) begin ce = ~m; oe = 1'b0; end
            rv = (k == ACC + 1);
        end
        return {ce, we, oe, oe_d, rdy, rv};
    endfunction

    function automatic string tag_of(input logic wr, input logic [3:0] m,
                                     input int k, input int total);
        if (m == 4'h0)  return "R10";
        if (k > total)  return "R2";
        if (!wr)        return (k <= ACC) ? "R9 R3" : "R8";
        if (k <= ASU)   return "R4 R3";
        if (k <= ASU + PW) return "R5 R6 R3";
        if (k <= ASU + PW + HLD) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the falling edge of the first idle cycle
    task automatic run_op(input logic wr, input logic [18:0] a, input logic [31:0] dat,
                          input logic [3:0] m, input logic poke);
        int total;
        total = (m == 4'h0) ? 0 : (wr ? ASU + PW + HLD + RECW : ACC + RECR);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_lanes = m;
        if (wr && m != 4'h0) begin
            logic [31:0] o;
            o = ref_mem.exists(a) ? ref_mem[a] : 32'h0;
            ref_mem[a] = (o & ~lbits(m)) | (dat & lbits(m));
        end
        for (int k = 1; k <= total + 1; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            check(tag_of(wr, m, k, total),
                  {17'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid},
                  {17'h0, exp_vec(wr, m, k, total)});
            if (|sram_dq_oe)
                check("R6 data", sram_dq_o & lbits(sram_dq_oe), dat & lbits(sram_dq_oe));
            if (!(&sram_ce_n)) check("R7 addr", {13'h0, sram_addr}, {13'h0, a});
            if (!wr && rsp_valid) begin
                logic [31:0] e;
                e = (m == 4'h0) ? 32'h0 :
                    ((ref_mem.exists(a) ? ref_mem[a] : 32'h0) & lbits(m));
                check((m == 4'h0) ? "R10 rdata" : "R9 rdata", rsp_rdata, e);
            end
            if (poke && k == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_lanes = 4'hF; req_wdata = ~dat;
            end
            if (poke && k == 3) req_valid = 1'b0;
        end
    endtask

    function automatic logic [18:0] pick_addr(input int unsigned r);
        case (r % 6)
            0: return 19'h00000;
            1: return 19'h7FFFF;
            2: return 19'h2AAAA;
            3: return 19'h55555;
            4: return 19'h00001;
            default: return 19'h40000;
        endcase
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 reset", {16'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid},
              {16'h0, 4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", {16'h0, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid},
              {16'h0, 4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 1'b0});

        run_op(1'b1, 19'h00000, 32'h11223344, 4'hF, 1'b0);
        run_op(1'b0, 19'h00000, 32'h0,        4'hF, 1'b0);
        run_op(1'b1, 19'h00000, 32'hAABBCCDD, 4'b0101, 1'b0);   // R3 partial
        run_op(1'b0, 19'h00000, 32'h0,        4'hF, 1'b0);
        run_op(1'b1, 19'h7FFFF, 32'h99887766, 4'b1000, 1'b0);
        run_op(1'b0, 19'h7FFFF, 32'h0,        4'b0110, 1'b0);
        run_op(1'b0, 19'h7FFFF, 32'h0,        4'hF, 1'b0);
        run_op(1'b1, 19'h00000, 32'hFFFFFFFF, 4'h0, 1'b0);      // R10 write
        run_op(1'b0, 19'h00000, 32'h0,        4'h0, 1'b0);      // R10 read
        run_op(1'b0, 19'h00000, 32'h0,        4'hF, 1'b0);
        run_op(1'b1, 19'h2AAAA, 32'h0F0F0F0F, 4'hF, 1'b1);      // R2 busy poke
        run_op(1'b0, 19'h2AAAA, 32'h0,        4'hF, 1'b1);
        run_op(1'b0, 19'h2AAAA, 32'h0,        4'hF, 1'b0);

        for (int i = 0; i < 80; i++) begin
            logic        wr;
            logic [3:0]  m;
            logic [31:0] dv;
            logic [18:0] a;
            wr = 1'($urandom);
            m  = 4'($urandom);
            dv = $urandom;
            a  = pick_addr($urandom);
            run_op(wr, a, dv, m, ($urandom % 4) == 0 && m != 4'h0);
        end
        for (int i = 0; i < 6; i++) run_op(1'b0, pick_addr(i), 32'h0, 4'hF, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule